// File: doc/BRIEF.md
# Vertical Line-Pair Subsampler

This block selects which sensor lines are read out when the array runs in a vertical subsampling mode. The timing generator pulses a strobe at the start of each frame and another at the end of each line. From these strobes the block raises or lowers a single line-enable flag that tells the readout path whether the current line is read or skipped. The timing generator then needs no skip logic of its own.

Lines are grouped in pairs, and both lines of a pair share one decision. A pair index counts pairs within a repeating group of up to eight. A 2-bit mode selects how many pairs are kept: all of them, one in two, one in four, or one in eight. The kept pair is always the first pair of each group. The mode is captured only when a frame starts, so a frame never mixes two patterns.

Top module: `line_pair_subsampler`

## Requirements
- R1: With a captured mode of 00, line_en_o is 1 on every line of the frame.
- R2: With a captured mode of 01, pairs whose index within the frame is even are read and odd pairs are skipped (line_en_o 1, 0, 1, 0 per pair).
- R3: With a captured mode of 10, pairs whose index is a multiple of 4 are read and the other three in each group of four are skipped.
- R4: With a captured mode of 11, pairs whose index is a multiple of 8 are read and the other seven in each group of eight are skipped.
- R5: The pair index advances once every two line_done_i strobes, so line_en_o is unchanged by the strobe that ends the first line of a pair.
- R6: A frame_start_i strobe clears the line and pair counts, and line_en_o is 1 in the cycle after it.
- R7: mode_i is captured only on frame_start_i; a mode_i change in mid-frame has no effect until the next frame start.
- R8: A synchronous active-high rst sets line_en_o to 1, clears the counts and sets the captured mode to 00.
- R9: When frame_start_i and line_done_i are high in the same cycle, the frame start wins and line_en_o is 1 in the next cycle.
- R10: line_en_o changes only in the cycle after a frame_start_i or line_done_i strobe and is held otherwise.
- R11: The pair index wraps within the group, so the keep pattern repeats across a frame longer than one group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Subsampling mode: 00 none, 01 half, 10 quarter, 11 eighth |
| frame_start_i | input | 1 | One-cycle strobe at the start of a frame |
| line_done_i | input | 1 | One-cycle strobe at the end of each line |
| line_en_o | output | 1 | Registered: 1 reads the current line, 0 skips it |

## Verification
The assertions assume that each strobe is a single-cycle pulse that the timing generator drives only between clock edges. They also assume that mode_i is meaningful only at a frame start. The stimulus drives every strobe for exactly one cycle at a falling edge and leaves at least one idle cycle before the next one. It changes mode_i freely in mid-frame so that the capture rule is exercised. The checker keeps its own record of the captured mode and the line parity, built only from the strobes, and it judges line_en_o against that record.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    SUB_NONE    = 2'b00,
    SUB_HALF    = 2'b01,
    SUB_QUARTER = 2'b10,
    SUB_EIGHTH  = 2'b11
  } sub_mode_e;
endpackage

// File: rtl/lps_mode_reg.sv
module lps_mode_reg
  import lps_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic [MODE_W-1:0] mode_in,
  output sub_mode_e         mode_q
);
  // The pattern for a frame is fixed at its start (R7)
  always_ff @(posedge clk) begin
    if (rst)              mode_q <= SUB_NONE;
    else if (frame_start) mode_q <= sub_mode_e'(mode_in);
  end
endmodule

// File: rtl/lps_pair_counter.sv
module lps_pair_counter #(
  parameter int PAIR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              line_done,
  output logic [PAIR_W-1:0] pair_next
);
  logic              second_line_q;
  logic [PAIR_W-1:0] pair_q;

  always_comb begin
    if (frame_start)                     pair_next = '0;
    else if (line_done && second_line_q) pair_next = pair_q + PAIR_W'(1);
    else                                 pair_next = pair_q;
  end

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      second_line_q <= 1'b0;
      pair_q        <= '0;
    end else if (line_done) begin
      second_line_q <= ~second_line_q;
      pair_q        <= pair_next;
    end
  end
endmodule

// File: rtl/lps_keep_decode.sv
module lps_keep_decode
  import lps_pkg::*;
#(
  parameter int PAIR_W = 3
) (
  input  sub_mode_e         mode,
  input  logic [PAIR_W-1:0] pair_idx,
  output logic              keep
);
  logic [PAIR_W-1:0] group_mask;

  // Group size is 2**mode pairs; only index 0 of each group is kept
  always_comb begin
    group_mask = PAIR_W'((32'd1 << mode) - 32'd1);
    keep       = ((pair_idx & group_mask) == '0);
  end
endmodule

// File: rtl/line_pair_subsampler.sv
module line_pair_subsampler
  import lps_pkg::*;
#(
  parameter int PAIR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              frame_start_i,
  input  logic              line_done_i,
  output logic              line_en_o
);
  sub_mode_e         mode_q;
  logic [PAIR_W-1:0] pair_next;
  logic              keep;

  lps_mode_reg u_mode (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start_i),
    .mode_in     (mode_i),
    .mode_q      (mode_q)
  );

  lps_pair_counter #(.PAIR_W(PAIR_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start_i),
    .line_done   (line_done_i),
    .pair_next   (pair_next)
  );

  lps_keep_decode #(.PAIR_W(PAIR_W)) u_dec (
    .mode     (mode_q),
    .pair_idx (pair_next),
    .keep     (keep)
  );

  always_ff @(posedge clk) begin
    if (rst)                              line_en_o <= 1'b1;
    else if (frame_start_i || line_done_i) line_en_o <= keep;
  end
endmodule

// File: rtl/lps_checker.sv
module lps_checker
  import lps_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [MODE_W-1:0] mode_i,
  input logic              frame_start_i,
  input logic              line_done_i,
  input logic              line_en_o
);
  logic [MODE_W-1:0] shadow_mode;
  logic              shadow_odd;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_mode <= '0;
      shadow_odd  <= 1'b0;
    end else if (frame_start_i) begin
      shadow_mode <= mode_i;
      shadow_odd  <= 1'b0;
    end else if (line_done_i) begin
      shadow_odd  <= ~shadow_odd;
    end
  end

  a_r8_reset_reads: assert property (@(posedge clk)
    rst |=> line_en_o);

  a_r6_frame_reads: assert property (@(posedge clk) disable iff (rst)
    frame_start_i |=> line_en_o);

  a_r9_frame_wins: assert property (@(posedge clk) disable iff (rst)
    (frame_start_i && line_done_i) |=> line_en_o);

  a_r1_mode0_all: assert property (@(posedge clk) disable iff (rst)
    (!frame_start_i && shadow_mode == 2'b00) |=> line_en_o);

  a_r5_first_line_hold: assert property (@(posedge clk) disable iff (rst)
    (line_done_i && !frame_start_i && !shadow_odd) |=> $stable(line_en_o));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!line_done_i && !frame_start_i) |=> $stable(line_en_o));
endmodule

bind line_pair_subsampler lps_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_i        (mode_i),
  .frame_start_i (frame_start_i),
  .line_done_i   (line_done_i),
  .line_en_o     (line_en_o)
);

// File: tb/tb_line_pair_subsampler.sv
module tb_line_pair_subsampler;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_i = 2'b00;
  logic       frame_start_i = 1'b0;
  logic       line_done_i = 1'b0;
  logic       line_en_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  bit    expq[$];
  string tagq[$];

  // Independent reference model
  int model_mode = 0;
  int model_lines = 0;

  line_pair_subsampler dut (
    .clk(clk), .rst(rst), .mode_i(mode_i),
    .frame_start_i(frame_start_i), .line_done_i(line_done_i),
    .line_en_o(line_en_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit model_keep();
    int pair;
    pair = model_lines / 2;
    return (pair % (1 << model_mode)) == 0;
  endfunction

  task automatic push(input string tag);
    expq.push_back(model_keep());
    tagq.push_back(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_mode = 0; model_lines = 0;
    push(tag);
  endtask

  task automatic frame(input logic [1:0] m, input string tag);
    @(negedge clk); mode_i = m; frame_start_i = 1'b1;
    @(negedge clk); frame_start_i = 1'b0;
    model_mode = m; model_lines = 0;
    push(tag);
  endtask

  task automatic frame_and_line(input logic [1:0] m, input string tag);
    @(negedge clk); mode_i = m; frame_start_i = 1'b1; line_done_i = 1'b1;
    @(negedge clk); frame_start_i = 1'b0; line_done_i = 1'b0;
    model_mode = m; model_lines = 0;
    push(tag);
  endtask

  task automatic line(input string tag);
    @(negedge clk); line_done_i = 1'b1;
    @(negedge clk); line_done_i = 1'b0;
    model_lines++;
    push(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) @(negedge clk);
    push(tag);
  endtask

  // Monitor: scoreboard compare after each posedge settles
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      while (expq.size() > 0) begin
        bit    e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        checks++;
        if (line_en_o !== e) begin
          failures++;
          $display("FAIL %s: line_en_o=%0b expected=%0b", t, line_en_o, e);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !done) begin
        failures++;
        checks++;
        $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    do_reset("R8 reset state");
    // R8: captured mode is 00 after reset even if mode_i differs
    mode_i = 2'b11;
    for (int i = 0; i < 6; i++) line("R8 mode 00 after reset");

    frame(2'b00, "R6 frame start reads");
    for (int i = 0; i < 8; i++) line("R1 mode 00 every line");

    frame(2'b01, "R6 frame start reads");
    for (int i = 0; i < 10; i++) line("R2 half pattern");

    frame(2'b10, "R6 frame start reads");
    for (int i = 0; i < 18; i++) line("R3 quarter pattern");

    frame(2'b11, "R6 frame start reads");
    for (int i = 0; i < 34; i++) line("R4 R11 eighth pattern with wrap");

    frame(2'b01, "R6 frame start reads");
    line("R5 first line of pair holds");
    idle(3, "R10 held while idle");
    line("R5 second line");
    line("R5 first line of skipped pair holds");
    idle(4, "R10 held while idle skip");

    // R7: change mode mid-frame, old pattern must continue
    frame(2'b10, "R6 frame start reads");
    for (int i = 0; i < 3; i++) line("R7 before change");
    mode_i = 2'b00;
    for (int i = 0; i < 9; i++) line("R7 mode change ignored mid-frame");
    frame(2'b00, "R7 new mode at frame start");
    for (int i = 0; i < 4; i++) line("R7 new mode applied");

    // R6: frame restart in the middle of a skipped region
    frame(2'b11, "R6 frame start reads");
    for (int i = 0; i < 5; i++) line("R4 before restart");
    frame(2'b11, "R6 restart mid-group reads");
    for (int i = 0; i < 4; i++) line("R6 counts cleared");

    // R9: simultaneous strobes
    for (int i = 0; i < 3; i++) line("R9 setup");
    frame_and_line(2'b01, "R9 frame start wins");
    for (int i = 0; i < 4; i++) line("R9 counting from zero");

    // R8: reset in mid-frame
    frame(2'b11, "R6 frame start reads");
    for (int i = 0; i < 3; i++) line("R8 setup");
    do_reset("R8 mid-frame reset");
    for (int i = 0; i < 4; i++) line("R8 mode 00 after mid-frame reset");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule